// File: doc/BRIEF.md
# Fractional Difference Weight Generator

This block fills a coefficient memory with the L weights of a truncated fractional-order difference operator, for a signed, generally non-integer order `c`. The weights follow a first-order recursion. Weight 0 is exactly one. Each later weight is the previous weight scaled by `1 - (1 + c)/j`. A positive `c` gives a fractional derivative and a negative `c` gives a fractional integral.

Software or a sequencer sets `order` and pulses `start`. The block then writes weights 0 to L-1 to the memory through `wr_en`, `wr_addr` and `wr_data`, one weight every fixed number of cycles, and raises `done` when the table is complete. It runs once before the filter starts taking samples, and again each time the order changes.

The reciprocal `1/j` comes from one of two variants, chosen by a parameter:
- a radix-2 restoring divider that takes one cycle per quotient bit;
- a single-cycle divide.

Each step costs one multiply by the reciprocal and one multiply by the previous weight. No factorials and no stored weight table are needed.

Top module: `glc_coef_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `wr_en`, `busy` and `done` are 0. A reset taken during a run abandons that run.
- R2: A start is accepted when `start` is 1 at a rising clock edge while `busy` is 0. In the next cycle `wr_en` is 1, `wr_addr` is 0 and `wr_data` is exactly 1.0, which is `1 << F` (0x020000 with the defaults).
- R3: Each accepted start produces exactly L writes, to addresses 0, 1, …, L-1 in ascending order.
- R4: All values are signed two's complement with W bits and F fraction bits. For each j ≥ 1, weight j is computed as follows:
  - `r = floor(2^RF / j)`;
  - `t = (2^F + c) * r`;
  - `tq = (t + 2^(RF-1)) >>> RF`;
  - `f = 2^F - tq`;
  - `p = b[j-1] * f`;
  - `b[j] = (p + 2^(F-1)) >>> F`, after saturation.

  All products are at full precision and `>>>` is an arithmetic shift. The saturated value of `b[j]` is stored and is also the value used in the next step.
- R5: Consecutive writes in one run are exactly PERIOD cycles apart. PERIOD is RF+3 when ITERATIVE=1 (the default, 27 cycles) and 2 when ITERATIVE=0.
- R6: A weight whose rounded value is above 2^(W-1)-1 is stored as 0x7FFFFF. One below -2^(W-1) is stored as 0x800000 (W=24).
- R7: `busy` is 1 from the cycle after an accepted start through the cycle of the last write. `done` is 1 from the next cycle on, until the next accepted start. `busy` and `done` are never 1 together, and `wr_en` is 1 only while `busy` is 1.
- R8: A `start` pulse while `busy` is 1 is ignored. The run continues with its address sequence and weights unchanged.
- R9: The order is captured at the accepted start. Changes on `order` during a run do not affect the weights written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to regenerate the table |
| order | input | W | Signed fractional order c, F fraction bits |
| wr_en | output | 1 | Coefficient memory write enable |
| wr_addr | output | $clog2(L) | Coefficient index being written |
| wr_data | output | W | Signed weight, F fraction bits |
| busy | output | 1 | Table generation in progress |
| done | output | 1 | Table complete for the captured order |

## Verification
The first write is due one cycle after the edge that accepts `start`. Each later write follows the previous one by exactly PERIOD cycles, and `done` rises one cycle after the write to address L-1. The bench drives inputs and samples outputs on the falling edge. It counts falling edges since the last observed write, so every write's spacing and address are compared against the counts the requirements give. The data of each write is compared with a bench model of the rounding and saturation rules in R4 and R6. Start pulses and order changes injected mid-run must leave that model's table unchanged.

// File: rtl/glc_pkg.sv
package glc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_DIV   = 2'd2,
      ST_FIN   = 2'd3
   } glc_state_e;
endpackage

// File: rtl/glc_recip.sv
// Reciprocal of a small positive index: r = floor(2^RF / den).
// ITERATIVE=1: restoring divider, one quotient bit per cycle.
// ITERATIVE=0: single-cycle divide, result valid the cycle after go.
module glc_recip #(
   parameter int AW        = 7,
   parameter int RF        = 24,
   parameter bit ITERATIVE = 1'b1,
   localparam int QB       = RF + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] den,
   output logic [QB-1:0] recip,
   output logic          valid
);
   generate
      if (ITERATIVE) begin : g_iter
         localparam int CW = $clog2(QB + 1);
         logic [AW-1:0] den_q;
         logic [AW:0]   rem;
         logic [QB-1:0] quo;
         logic [CW-1:0] cnt;
         logic          run;
         logic [AW:0]   trial;

         always_comb begin
            trial = {rem[AW-1:0], (cnt == CW'(QB))};
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               den_q <= '0;
               rem   <= '0;
               quo   <= '0;
               cnt   <= '0;
               run   <= 1'b0;
            end else if (go) begin
               den_q <= den;
               rem   <= '0;
               quo   <= '0;
               cnt   <= CW'(QB);
               run   <= 1'b1;
            end else if (cnt != '0) begin
               if (trial >= {1'b0, den_q}) begin
                  rem <= trial - {1'b0, den_q};
                  quo <= {quo[QB-2:0], 1'b1};
               end else begin
                  rem <= trial;
                  quo <= {quo[QB-2:0], 1'b0};
               end
               cnt <= cnt - CW'(1);
            end
         end

         assign recip = quo;
         assign valid = run && (cnt == '0);
      end else begin : g_direct
         localparam logic [QB-1:0] NUM = QB'(1) << RF;
         logic [QB-1:0] r_q;
         logic          v_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_q <= '0;
               v_q <= 1'b0;
            end else if (go) begin
               r_q <= NUM / QB'(den);
               v_q <= 1'b1;
            end
         end

         assign recip = r_q;
         assign valid = v_q;
      end
   endgenerate
endmodule

// File: rtl/glc_step.sv
// One recursion step: b_next = sat(round(b_prev * (1 - round((1+c)*r)))).
module glc_step #(
   parameter int W  = 24,
   parameter int F  = 17,
   parameter int RF = 24,
   localparam int QB = RF + 1,
   localparam int TW = W + RF + 4,
   localparam int PW = W + TW
) (
   input  logic signed [W-1:0] b_prev,
   input  logic signed [W-1:0] c,
   input  logic        [QB-1:0] recip,
   output logic signed [W-1:0] b_next
);
   localparam logic signed [TW-1:0] ONE_T  = TW'(1) <<< F;
   localparam logic signed [TW-1:0] HALF_R = TW'(1) <<< (RF - 1);
   localparam logic signed [PW-1:0] HALF_F = PW'(1) <<< (F - 1);
   localparam logic signed [PW-1:0] MAXV   = (PW'(1) <<< (W - 1)) - PW'(1);
   localparam logic signed [PW-1:0] MINV   = -(PW'(1) <<< (W - 1));

   logic signed [TW-1:0] onepc, rr, t, tq, f;
   logic signed [PW-1:0] bp, pr;

   always_comb begin
      onepc = TW'(c) + ONE_T;
      rr    = TW'(recip);
      t     = onepc * rr;
      tq    = (t + HALF_R) >>> RF;
      f     = ONE_T - tq;
      bp    = PW'(b_prev) * PW'(f);
      pr    = (bp + HALF_F) >>> F;
      if (pr > MAXV)      b_next = MAXV[W-1:0];
      else if (pr < MINV) b_next = MINV[W-1:0];
      else                b_next = pr[W-1:0];
   end
endmodule

// File: rtl/glc_coef_gen.sv
module glc_coef_gen #(
   parameter int W         = 24,
   parameter int F         = 17,
   parameter int L         = 100,
   parameter int RF        = 24,
   parameter bit ITERATIVE = 1'b1,
   localparam int AW       = $clog2(L),
   localparam int QB       = RF + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic signed [W-1:0] order,
   output logic                wr_en,
   output logic [AW-1:0]       wr_addr,
   output logic signed [W-1:0] wr_data,
   output logic                busy,
   output logic                done
);
   import glc_pkg::*;

   generate
      if (L < 2) begin : g_bad_l
         $error("glc_coef_gen: L must be at least 2");
      end
      if (F < 1 || F >= W - 1) begin : g_bad_f
         $error("glc_coef_gen: F must lie in 1..W-2");
      end
      if (RF < F) begin : g_bad_rf
         $error("glc_coef_gen: RF must not be below F");
      end
   endgenerate

   localparam logic signed [W-1:0] ONE  = W'(1) <<< F;
   localparam logic [AW-1:0]       LAST = AW'(L - 1);

   glc_state_e           state;
   logic [AW-1:0]        idx;
   logic signed [W-1:0]  b_q, c_q, b_nx;
   logic [QB-1:0]        recip;
   logic                 r_valid, go;
   logic [AW-1:0]        den;

   assign go  = (state == ST_WRITE) && (idx != LAST);
   assign den = idx + AW'(1);

   glc_recip #(.AW(AW), .RF(RF), .ITERATIVE(ITERATIVE)) u_recip (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .den   (den),
      .recip (recip),
      .valid (r_valid)
   );

   glc_step #(.W(W), .F(F), .RF(RF)) u_step (
      .b_prev (b_q),
      .c      (c_q),
      .recip  (recip),
      .b_next (b_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         b_q   <= '0;
         c_q   <= '0;
      end else begin
         case (state)
            ST_IDLE, ST_FIN: begin
               if (start) begin
                  c_q   <= order;
                  idx   <= '0;
                  b_q   <= ONE;
                  state <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (idx == LAST) begin
                  state <= ST_FIN;
               end else begin
                  idx   <= den;
                  state <= ST_DIV;
               end
            end
            ST_DIV: begin
               if (r_valid) begin
                  b_q   <= b_nx;
                  state <= ST_WRITE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign wr_en   = (state == ST_WRITE);
   assign wr_addr = idx;
   assign wr_data = b_q;
   assign busy    = (state == ST_WRITE) || (state == ST_DIV);
   assign done    = (state == ST_FIN);
endmodule

// File: rtl/glc_coef_gen_chk.sv
module glc_coef_gen_chk #(
   parameter int W         = 24,
   parameter int F         = 17,
   parameter int L         = 100,
   parameter int RF        = 24,
   parameter bit ITERATIVE = 1'b1,
   localparam int AW       = $clog2(L)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic signed [W-1:0] order,
   input logic                wr_en,
   input logic [AW-1:0]       wr_addr,
   input logic signed [W-1:0] wr_data,
   input logic                busy,
   input logic                done
);
   localparam int PERIOD = ITERATIVE ? RF + 3 : 2;
   localparam int GW     = $clog2(PERIOD + 2) + 1;
   localparam logic signed [W-1:0] ONE = W'(1) <<< F;

   logic [GW-1:0] gap;
   logic [AW-1:0] last_addr;
   logic          seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap       <= '0;
         last_addr <= '0;
         seen      <= 1'b0;
      end else if (wr_en) begin
         gap       <= GW'(1);
         last_addr <= wr_addr;
         seen      <= 1'b1;
      end else if (gap != '1) begin
         gap <= gap + GW'(1);
      end
   end

   p_wr_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);
   p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
   p_first_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |-> (wr_data == ONE));
   p_addr_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0 && seen) |-> (wr_addr == last_addr + AW'(1)));
   p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0 && seen) |-> (gap == GW'(PERIOD)));
   p_start_ign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wr_en && start) |=> !(wr_en && wr_addr == '0));
endmodule

bind glc_coef_gen glc_coef_gen_chk #(
   .W(W), .F(F), .L(L), .RF(RF), .ITERATIVE(ITERATIVE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .order   (order),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .busy    (busy),
   .done    (done)
);

// File: tb/tb_glc_coef_gen.sv
`timescale 1ns/1ps
module tb_glc_coef_gen;
   localparam int W      = 24;
   localparam int F      = 17;
   localparam int L      = 100;
   localparam int RF     = 24;
   localparam int AW     = $clog2(L);
   localparam int PERIOD = RF + 3;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic signed [W-1:0] order = '0;
   logic                wr_en;
   logic [AW-1:0]       wr_addr;
   logic signed [W-1:0] wr_data;
   logic                busy, done;

   int n_checks = 0;
   int n_errors = 0;
   longint exp_tab [L];

   always #2.5 clk = ~clk;

   glc_coef_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .order(order),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R4/R6 model
   function automatic void build_exp(input longint c);
      longint b, r, t, tq, f, p, pr;
      longint maxv = (64'sd1 <<< (W - 1)) - 1;
      longint minv = -(64'sd1 <<< (W - 1));
      b = 64'sd1 <<< F;
      exp_tab[0] = b;
      for (int j = 1; j < L; j++) begin
         r  = (64'sd1 <<< RF) / j;
         t  = (c + (64'sd1 <<< F)) * r;
         tq = (t + (64'sd1 <<< (RF - 1))) >>> RF;
         f  = (64'sd1 <<< F) - tq;
         p  = b * f;
         pr = (p + (64'sd1 <<< (F - 1))) >>> F;
         if (pr > maxv) pr = maxv;
         else if (pr < minv) pr = minv;
         b = pr;
         exp_tab[j] = b;
      end
   endfunction

   task automatic run_case(input int c, input string tag, input bit poke);
      int     got_n = 0;
      int     since = 0;
      int     cyc = 0;
      bit     poked = 1'b0;
      longint got [L];
      build_exp(longint'(c));
      @(negedge clk);
      order = W'(c);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: first write one cycle after accept
      check(wr_en && wr_addr == '0, "R2 first write addr0", longint'(wr_addr), 0);
      check(wr_data == (W'(1) <<< F), "R2 first data", longint'(wr_data), 64'sd1 <<< F);
      check(busy && !done, "R7 busy after start", longint'(busy), 1);
      if (wr_en) begin
         got[0] = longint'(wr_data);
         got_n = 1;
      end
      while (cyc < 20000) begin
         @(negedge clk);
         start = 1'b0;
         cyc++;
         since++;
         if (done) break;
         if (wr_en) begin
            check(int'(wr_addr) == got_n, "R3 ascending address", longint'(wr_addr), got_n);
            check(since == PERIOD, "R5 write spacing", since, PERIOD);
            if (got_n < L) got[got_n] = longint'(wr_data);
            got_n++;
            since = 0;
         end else if (poke && !poked && got_n == 3) begin
            // R8, R9: start pulse and order change while busy
            start = 1'b1;
            order = W'(c ^ 32'h0000_5a5a);
            poked = 1'b1;
         end
      end
      check(done, "R7 done reached", longint'(done), 1);
      check(since == 1, "R7 done one cycle after last write", since, 1);
      check(got_n == L, "R3 write count", got_n, L);
      for (int k = 0; k < L && k < got_n; k++) begin
         check(got[k] == exp_tab[k], {tag, " weight"}, got[k], exp_tab[k]);
      end
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(done && !busy && !wr_en, "R7 done holds", longint'(done), 1);
      end
      order = W'(c);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      int seed_v;
      seed_v = $urandom(32'd20240611);
      // R1 reset state, start held during reset is ignored
      start = 1'b1;
      repeat (3) @(negedge clk);
      check(!wr_en && !busy && !done, "R1 reset outputs", longint'(busy), 0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(!wr_en && !busy && !done, "R1 after reset release", longint'(busy), 0);

      run_case(26214,   "R4 c=0.2", 1'b0);
      run_case(-78643,  "R4 c=-0.6", 1'b0);
      run_case(129761,  "R4 c=0.99", 1'b1);   // R8 R9
      run_case(0,       "R4 c=0", 1'b0);
      run_case(-131072, "R4 c=-1", 1'b0);
      run_case(60 <<< F, "R6 saturate", 1'b0);
      run_case(-(40 <<< F), "R6 large negative", 1'b1);

      for (int n = 0; n < 6; n++) begin
         int c;
         c = int'($urandom_range(393216, 0)) - 196608;
         run_case(c, "R4 random", n[0]);
      end

      // R1: reset mid-run abandons it
      @(negedge clk);
      order = W'(26214);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(!wr_en && !busy && !done, "R1 reset mid-run", longint'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done, "R1 idle after mid-run reset", longint'(done), 0);
      run_case(-78643, "R4 after reset", 1'b0);

      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule